// File: doc/BRIEF.md
# CAN Transceiver Mode and Fail-Safe Controller

This block is the digital control core of a high-speed CAN physical-layer interface. It takes the controller's transmit data, a silent-select pin, the receive comparator's bus-dominant flag and three analog status flags: main-supply undervoltage, I/O-supply undervoltage and overtemperature. From these it decides whether the interface is powered down (Off), actively driving (Normal) or listen-only (Silent). It then drives the transmitter enable, the dominant command, the bus-bias enable, the receive data pin and that pin's output enable.

Every input first passes through a synchronizer. All time limits are counted in system clock cycles: supply fault detection, supply recovery, start-up and the glitch filter on the mode pin. The transmitter is a fail-safe output. After any entry into Normal mode, any recovery from Off and any thermal shutdown, it stays disabled until the transmit input has been seen HIGH once. A controller stuck at dominant can therefore never capture the bus.

Top module: `canx_phy_ctrl`

## Requirements
- R1: During and after reset the block is in Off: `mode_o` = 0 (encoding Off=0, Normal=1, Silent=2), and `drv_en_o`, `bias_en_o` and `rxd_oe_o` are 0.
- R2: A main-supply undervoltage flag that is seen for UV_MAIN_DET_CYC consecutive synchronized cycles forces Off. With two-stage synchronizers the mode changes three cycles after the last counted cycle. A shorter assertion restarts the count and leaves the mode unchanged.
- R3: The I/O-supply undervoltage flag has its own count, UV_IO_DET_CYC, and behaves the same way.
- R4: Off is left only after the main supply has been good for MAIN_REC_CYC cycles and the I/O supply has been good for IO_START_CYC cycles. The new mode is the one the filtered mode pin selects at that moment, and changes of the mode pin during Off have no other effect.
- R5: In Silent (`sel_silent_i` = 1) the driver is disabled whatever the transmit input does, the bias stays enabled, and `rxd_o` is the inverse of `bus_dom_i`.
- R6: In Normal with the driver armed, `txd_i` = 0 gives `drv_dom_o` = 1 and `txd_i` = 1 gives `drv_dom_o` = 0. `rxd_o` follows the bus as in R5, and `drv_dom_o` is never 1 while `drv_en_o` is 0.
- R7: After entering Normal and after leaving Off, `drv_en_o` stays 0 until a HIGH transmit input has been synchronized. It rises one cycle after that.
- R8: When the overtemperature flag is set, the driver turns off as soon as the flag is synchronized. It turns on again only when three conditions hold: the flag has cleared, Normal is selected and the transmit input is seen HIGH.
- R9: A mode-pin pulse lasting fewer than FLT_CYC synchronized cycles is rejected, and one lasting FLT_CYC cycles is accepted. FLT_CYC is the midpoint of FLT_REJECT_CYC and FLT_ACCEPT_CYC.
- R10: A qualified mode-pin change takes effect exactly SYNC_STAGES + FLT_CYC + 1 cycles after the pin changes. Elaboration guarantees that this is at most MOCH_CYC.
- R11: In Off the receive output is tri-stated (`rxd_oe_o` = 0) and the bias is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit data from the controller, LOW = dominant |
| sel_silent_i | input | 1 | Mode pin: LOW = Normal, HIGH = Silent |
| bus_dom_i | input | 1 | Receive comparator flag, 1 = bus dominant |
| uv_main_i | input | 1 | Main-supply undervoltage flag |
| uv_io_i | input | 1 | I/O-supply undervoltage flag |
| ot_i | input | 1 | Overtemperature flag (hysteresis applied in the analog domain) |
| mode_o | output | 2 | Current mode: 0 Off, 1 Normal, 2 Silent |
| drv_en_o | output | 1 | Transmit driver enable |
| drv_dom_o | output | 1 | Drive-dominant command |
| bias_en_o | output | 1 | Mid-supply bus bias enable |
| rxd_o | output | 1 | Receive data, LOW = dominant |
| rxd_oe_o | output | 1 | Output enable for the receive pin |

## Verification
Three functions can act in the same cycle: entry into Normal, driver arming and thermal release. Normal can be reached through the mode filter while the transmit input is held LOW, and the driver must then stay off even though the mode has already changed. Thermal release is provoked with the transmit input also LOW, and is judged by the driver staying disabled until transmit goes HIGH and then enabling exactly one cycle after synchronization. Supply detection and recovery counts are probed at the exact threshold and one cycle short, and each boundary is judged at the precise edge where the mode must or must not change.

// File: rtl/canx_ctl_pkg.sv
package canx_ctl_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_NORMAL = 2'd1,
      MODE_SILENT = 2'd2
   } op_mode_e;

   // index of each synchronized input in the sync vector
   localparam int SI_TXD  = 0;
   localparam int SI_SEL  = 1;
   localparam int SI_BUS  = 2;
   localparam int SI_UVM  = 3;
   localparam int SI_UVIO = 4;
   localparam int SI_OT   = 5;
   localparam int SI_NUM  = 6;

   // reset values: transmit and mode pin pulled high, supplies assumed bad
   localparam logic [SI_NUM-1:0] SI_RST = 6'b011011;

endpackage

// File: rtl/canx_sync.sv
module canx_sync #(
   parameter int WIDTH              = 1,
   parameter int STAGES             = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("canx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/canx_persist.sv
module canx_persist #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic hit
);

   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("canx_persist: LIMIT must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!level)              cnt <= '0;
      else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
   end

   assign hit = (cnt == CW'(LIMIT));

endmodule

// File: rtl/canx_mode_filter.sv
module canx_mode_filter #(
   parameter int FLT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);

   localparam int CW = $clog2(FLT_CYC + 1);

   generate
      if (FLT_CYC < 1) begin : g_bad
         $error("canx_mode_filter: FLT_CYC must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         filt <= 1'b1;
      end else if (raw == filt) begin
         cnt  <= '0;
      end else if (cnt == CW'(FLT_CYC - 1)) begin
         cnt  <= '0;
         filt <= raw;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/canx_phy_ctrl.sv
module canx_phy_ctrl
   import canx_ctl_pkg::*;
#(
   parameter int SYNC_STAGES     = 2,
   parameter int UV_MAIN_DET_CYC = 7500,
   parameter int UV_IO_DET_CYC   = 7500,
   parameter int MAIN_REC_CYC    = 12500,
   parameter int IO_START_CYC    = 250000,
   parameter int FLT_REJECT_CYC  = 250,
   parameter int FLT_ACCEPT_CYC  = 1250,
   parameter int MOCH_CYC        = 12500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       txd_i,
   input  logic       sel_silent_i,
   input  logic       bus_dom_i,
   input  logic       uv_main_i,
   input  logic       uv_io_i,
   input  logic       ot_i,
   output logic [1:0] mode_o,
   output logic       drv_en_o,
   output logic       drv_dom_o,
   output logic       bias_en_o,
   output logic       rxd_o,
   output logic       rxd_oe_o
);

   localparam int FLT_CYC  = (FLT_REJECT_CYC + FLT_ACCEPT_CYC) / 2;
   localparam int MODE_LAT = SYNC_STAGES + FLT_CYC + 1;
   localparam int N_TMR    = 4;

   generate
      if (FLT_REJECT_CYC >= FLT_ACCEPT_CYC) begin : g_bad_flt
         $error("canx_phy_ctrl: reject window must be below accept window");
      end
      if (MODE_LAT > MOCH_CYC) begin : g_bad_moch
         $error("canx_phy_ctrl: mode change latency exceeds MOCH_CYC");
      end
   endgenerate

   // timer 0: main fault, 1: io fault, 2: main good, 3: io good
   function automatic int tmr_limit(input int idx);
      case (idx)
         0:       return UV_MAIN_DET_CYC;
         1:       return UV_IO_DET_CYC;
         2:       return MAIN_REC_CYC;
         default: return IO_START_CYC;
      endcase
   endfunction

   // ---------------- input synchronization ----------------
   logic [SI_NUM-1:0] raw_in, syn;

   assign raw_in = {ot_i, uv_io_i, uv_main_i, bus_dom_i, sel_silent_i, txd_i};

   canx_sync #(.WIDTH(SI_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SI_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   logic txd_s, bus_s, uv_main_s, uv_io_s, ot_s, sel_filt;

   assign txd_s     = syn[SI_TXD];
   assign bus_s     = syn[SI_BUS];
   assign uv_main_s = syn[SI_UVM];
   assign uv_io_s   = syn[SI_UVIO];
   assign ot_s      = syn[SI_OT];

   canx_mode_filter #(.FLT_CYC(FLT_CYC)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (syn[SI_SEL]),
      .filt  (sel_filt)
   );

   // ---------------- supply persistence timers ----------------
   logic [N_TMR-1:0] tmr_lvl, tmr_hit;

   assign tmr_lvl = {~uv_io_s, ~uv_main_s, uv_io_s, uv_main_s};

   for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
      canx_persist #(.LIMIT(tmr_limit(gi))) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .level (tmr_lvl[gi]),
         .hit   (tmr_hit[gi])
      );
   end

   // ---------------- mode sequencing ----------------
   op_mode_e state, state_nxt, sel_mode;
   logic     uv_trip, sup_ok;

   assign uv_trip  = tmr_hit[0] | tmr_hit[1];
   assign sup_ok   = tmr_hit[2] & tmr_hit[3];
   assign sel_mode = sel_filt ? MODE_SILENT : MODE_NORMAL;

   always_comb begin
      if (uv_trip)                state_nxt = MODE_OFF;
      else if (state == MODE_OFF) state_nxt = sup_ok ? sel_mode : MODE_OFF;
      else                        state_nxt = sel_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= MODE_OFF;
      else        state <= state_nxt;
   end

   // ---------------- driver arming ----------------
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             armed <= 1'b0;
      else if (state != MODE_NORMAL || ot_s)  armed <= 1'b0;
      else if (txd_s)                         armed <= 1'b1;
   end

   // ---------------- outputs ----------------
   logic active;

   assign active    = (state != MODE_OFF);
   assign mode_o    = state;
   assign drv_en_o  = armed && (state == MODE_NORMAL) && !ot_s;
   assign drv_dom_o = drv_en_o && !txd_s;
   assign bias_en_o = active;
   assign rxd_oe_o  = active;
   assign rxd_o     = active ? ~bus_s : 1'b1;

endmodule

// File: rtl/canx_phy_ctrl_chk.sv
module canx_phy_ctrl_chk
   import canx_ctl_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_o,
   input logic       drv_en_o,
   input logic       drv_dom_o,
   input logic       bias_en_o,
   input logic       rxd_oe_o,
   input logic       txd_s,
   input logic       uv_main_s,
   input logic       uv_io_s,
   input logic       sel_filt
);

   // R11 / R1: Off keeps everything released
   a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == MODE_OFF |-> (!drv_en_o && !bias_en_o && !rxd_oe_o));

   // R5: no driving in listen-only mode
   a_r5_silent_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o == MODE_SILENT |-> !drv_en_o);

   // R6: dominant command only with enabled driver
   a_r6_dom_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      drv_dom_o |-> drv_en_o);

   // R7: enable rises only after a HIGH transmit level was seen
   a_r7_arm_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en_o) |-> $past(txd_s));

   // R4: leaving Off needs both supplies good on the previous cycle
   a_r4_exit_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == MODE_OFF && mode_o != MODE_OFF) |->
         ($past(!uv_main_s) && $past(!uv_io_s)));

   // R10: a Normal/Silent swap lands on the filtered selection
   a_r10_follows_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != MODE_OFF && $past(mode_o) != MODE_OFF && $past(mode_o) != mode_o) |->
         (mode_o == ($past(sel_filt) ? MODE_SILENT : MODE_NORMAL)));

endmodule

bind canx_phy_ctrl canx_phy_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_o    (mode_o),
   .drv_en_o  (drv_en_o),
   .drv_dom_o (drv_dom_o),
   .bias_en_o (bias_en_o),
   .rxd_oe_o  (rxd_oe_o),
   .txd_s     (txd_s),
   .uv_main_s (uv_main_s),
   .uv_io_s   (uv_io_s),
   .sel_filt  (sel_filt)
);

// File: tb/canx_phy_ctrl_test.sv
module canx_phy_ctrl_test;

   localparam int SYNC = 2;
   localparam int L_M  = 8;
   localparam int L_IO = 6;
   localparam int R_M  = 12;
   localparam int S_IO = 20;
   localparam int REJ  = 3;
   localparam int ACC  = 7;
   localparam int FLT  = (REJ + ACC) / 2;
   localparam int MLAT = SYNC + FLT + 1;

   localparam int OFF = 0, NRM = 1, SIL = 2;

   logic clk = 1'b0;
   logic rst_n, txd, sel, bus, uvm, uvio, ot;
   logic [1:0] mode;
   logic drv_en, drv_dom, bias_en, rxd, rxd_oe;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   canx_phy_ctrl #(
      .SYNC_STAGES(SYNC), .UV_MAIN_DET_CYC(L_M), .UV_IO_DET_CYC(L_IO),
      .MAIN_REC_CYC(R_M), .IO_START_CYC(S_IO), .FLT_REJECT_CYC(REJ),
      .FLT_ACCEPT_CYC(ACC), .MOCH_CYC(12)
   ) uut (
      .clk(clk), .rst_n(rst_n), .txd_i(txd), .sel_silent_i(sel),
      .bus_dom_i(bus), .uv_main_i(uvm), .uv_io_i(uvio), .ot_i(ot),
      .mode_o(mode), .drv_en_o(drv_en), .drv_dom_o(drv_dom),
      .bias_en_o(bias_en), .rxd_o(rxd), .rxd_oe_o(rxd_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drv_edge();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; txd = 1'b1; sel = 1'b0; bus = 1'b0;
      uvm = 1'b0; uvio = 1'b0; ot = 1'b0;
      tick(3);
      check("R1 mode", mode, OFF);
      check("R1 drv_en", drv_en, 0);
      check("R1 bias", bias_en, 0);
      check("R1 rxd_oe", rxd_oe, 0);

      // start-up recovery: I/O start-up count is the longer one
      drv_edge(); rst_n = 1'b1;
      tick(S_IO + 2);
      check("R4 still off before start-up", mode, OFF);
      tick(1);
      check("R4 normal after start-up", mode, NRM);
      check("R7 not armed on entry", drv_en, 0);
      tick(1);
      check("R7 armed after txd high", drv_en, 1);

      // R6 transmit and receive paths
      drv_edge(); txd = 1'b0;
      tick(2);
      check("R6 dominant", drv_dom, 1);
      drv_edge(); bus = 1'b1;
      tick(2);
      check("R6 rxd dominant", rxd, 0);
      drv_edge(); bus = 1'b0; txd = 1'b1;
      tick(2);
      check("R6 rxd recessive", rxd, 1);
      check("R6 recessive", drv_dom, 0);

      // R2 two just-too-short main glitches separated by one good cycle
      drv_edge(); uvm = 1'b1;
      tick(L_M - 1);
      drv_edge(); uvm = 1'b0;
      tick(0);
      drv_edge(); uvm = 1'b1;
      tick(L_M - 1);
      drv_edge(); uvm = 1'b0;
      tick(L_M + 4);
      check("R2 short glitch ignored", mode, NRM);
      check("R2 driver kept", drv_en, 1);

      // R2 exact threshold
      drv_edge(); uvm = 1'b1;
      tick(L_M + 2);
      check("R2 before threshold", mode, NRM);
      tick(1);
      check("R2 off at threshold", mode, OFF);
      check("R11 rxd tri-state", rxd_oe, 0);
      check("R11 bias off", bias_en, 0);

      // R4 mode toggles during Off
      drv_edge(); sel = 1'b1;
      tick(10);
      drv_edge(); sel = 1'b0;
      tick(10);
      check("R4 toggle in off ignored", mode, OFF);
      drv_edge(); sel = 1'b1;
      tick(12);
      check("R4 still off", mode, OFF);
      drv_edge(); uvm = 1'b0;
      tick(R_M + 2);
      check("R4 main recovery pending", mode, OFF);
      tick(1);
      check("R4 exit to selected silent", mode, SIL);

      // R5 silent behaviour
      drv_edge(); txd = 1'b0; bus = 1'b1;
      tick(3);
      check("R5 no drive", drv_en, 0);
      check("R5 bias on", bias_en, 1);
      check("R5 rxd dominant", rxd, 0);
      drv_edge(); bus = 1'b0;
      tick(2);
      check("R5 rxd recessive", rxd, 1);

      // R9 rejected pulse
      drv_edge(); sel = 1'b0;
      tick(FLT - 1);
      drv_edge(); sel = 1'b1;
      tick(12);
      check("R9 short pulse rejected", mode, SIL);

      // R10 latency, R7 entry with txd LOW
      drv_edge(); sel = 1'b0;
      tick(MLAT - 1);
      check("R10 before latency", mode, SIL);
      tick(1);
      check("R10 normal at latency", mode, NRM);
      tick(3);
      check("R7 held while txd low", drv_en, 0);
      drv_edge(); txd = 1'b1;
      tick(2);
      check("R7 not yet armed", drv_en, 0);
      tick(1);
      check("R7 armed", drv_en, 1);

      // R9 accepted pulse of exactly FLT cycles
      drv_edge(); sel = 1'b1;
      tick(FLT);
      drv_edge(); sel = 1'b0;
      tick(3);
      check("R9 exact pulse accepted", mode, SIL);
      tick(12);
      check("R9 back to normal", mode, NRM);
      check("R7 re-armed", drv_en, 1);

      // R3 I/O supply: short then exact
      drv_edge(); uvio = 1'b1;
      tick(L_IO - 1);
      drv_edge(); uvio = 1'b0;
      tick(L_IO + 4);
      check("R3 short glitch ignored", mode, NRM);
      drv_edge(); uvio = 1'b1;
      tick(L_IO + 2);
      check("R3 before threshold", mode, NRM);
      tick(1);
      check("R3 off at threshold", mode, OFF);
      drv_edge(); uvio = 1'b0;
      tick(S_IO + 2);
      check("R3 start-up pending", mode, OFF);
      tick(1);
      check("R4 normal after io start-up", mode, NRM);
      check("R7 off after recovery", drv_en, 0);
      tick(1);
      check("R7 armed after recovery", drv_en, 1);

      // R8 thermal shutdown and release with txd LOW
      drv_edge(); ot = 1'b1;
      tick(2);
      check("R8 shutdown", drv_en, 0);
      check("R8 no dominant", drv_dom, 0);
      drv_edge(); txd = 1'b0; ot = 1'b0;
      tick(10);
      check("R8 held with txd low", drv_en, 0);
      drv_edge(); txd = 1'b1;
      tick(2);
      check("R8 not yet", drv_en, 0);
      tick(1);
      check("R8 released", drv_en, 1);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule